// File: doc/BRIEF.md
# CAN Bit Timing and Synchronization Unit

This block divides the system clock into time quanta and steps every bus bit through four segments: a single-quantum synchronization segment, a propagation segment, phase segment 1 and phase segment 2. It marks the start of each bit with a one-clock strobe. That strobe is also the point at which a transmitter drives its next bit. A second one-clock strobe marks the sample point, and the sampled bus value is presented there. A protocol engine sits above this unit. It supplies the timing configuration, a flag saying the bus is idle, and a flag saying this node is currently driving a dominant level. It consumes the bit stream.

Receivers drift against the transmitter, so the unit watches the receive line for recessive-to-dominant transitions. The first such transition seen while the bus is idle starts a new bit on the spot. Any later transition moves the sample point or the end of the bit by a bounded amount, at most once per bit. A majority vote over three quantum-spaced samples can be selected in place of a single sample, which filters short glitches.

Top module: `cbt_bit_timer`

## Requirements
- R1: One quantum lasts `brp`+1 clocks. With no edges, a bit lasts 1+`prop_len`+`ph1_len`+`ph2_len` quanta, and `bit_start_stb` is high for one clock at the start of each synchronization quantum. Legal settings are `prop_len` and `ph1_len` in 1..8, `ph2_len` in 2..8, `sjw_len` below `ph2_len`, and `prop_len`+`ph1_len` not below `ph2_len`.
- R2: With no edges, `sample_stb` is high for one clock exactly (1+`prop_len`+`ph1_len`) quanta after the clock in which `bit_start_stb` is high. `rx_bit` takes the sampled value in that same clock and changes at no other time. The two strobes are never high together.
- R3: A high-to-low change of `rx_in` while `bus_idle` is 1 forces `bit_start_stb` two clocks later (hard synchronization) from any point in the bit. Only the first such edge is honoured until `bus_idle` has been 0. After a hard sync the next sample follows after the nominal distance.
- R4: A falling edge detected during the quantum with index k (0-based) after the synchronization quantum and before the sample point delays the sample point by min(k+1, `sjw_len`) quanta.
- R5: A falling edge detected in phase 2 quantum k is early by e = `ph2_len`−k quanta. If e ≤ `sjw_len`, a new bit starts at once, with `bit_start_stb` in the next clock. Otherwise phase 2 is cut by `sjw_len` quanta.
- R6: At most one resynchronization is applied per bit. Rising edges of `rx_in` never move the timing.
- R7: Falling edges seen while `tx_dom` is 1 cause no resynchronization.
- R8: When `triple_en` is 1, `rx_bit` is the majority of the receive level at the ends of the last three quanta up to and including the sample point. When `triple_en` is 0, only the final one is used.
- R9: During and right after reset, `rx_bit` is 1 and both strobes are 0. The first bit begins in its synchronization quantum when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| brp | input | BRP_W | Prescaler setting; quantum = brp+1 clocks |
| prop_len | input | SEG_W | Propagation segment length in quanta |
| ph1_len | input | SEG_W | Phase 1 length in quanta |
| ph2_len | input | SEG_W | Phase 2 length in quanta |
| sjw_len | input | SEG_W | Resynchronization jump limit in quanta |
| triple_en | input | 1 | Selects three-sample majority |
| bus_idle | input | 1 | Bus has been recessive long enough to be idle |
| tx_dom | input | 1 | This node is driving a dominant level |
| rx_in | input | 1 | Raw receive line (1 = recessive) |
| rx_bit | output | 1 | Sampled bus value |
| sample_stb | output | 1 | One-clock pulse at the sample point |
| bit_start_stb | output | 1 | One-clock pulse at the start of each bit |

## Verification
Some properties are checked on every cycle: the sample point always falls between its nominal distance from the bit start and that distance plus the jump limit, a bit never runs longer than its nominal length plus the jump limit, the sampled value holds between strobes, the strobes never coincide, and the configuration stays legal. Which way an edge moves the timing, and by how much, can only be shown by the directed scenarios. Those scenarios place edges in chosen quanta and measure strobe distances. The same holds for hard sync being honoured once per idle period, edges being ignored during own transmission or after a resync, and the majority vote rejecting a one-quantum glitch.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

   typedef enum logic [1:0] {
      SEG_SYNC = 2'd0,
      SEG_TS1  = 2'd1,
      SEG_PH2  = 2'd2
   } cbt_seg_e;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/cbt_quantum_gen.sv
module cbt_quantum_gen #(
   parameter int BRP_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BRP_W-1:0] brp,
   input  logic             restart,
   output logic             tq_tick
);
   logic [BRP_W-1:0] div_q;

   assign tq_tick = (div_q >= brp) && !restart;

   always_ff @(posedge clk) begin
      if (!rst_n)              div_q <= '0;
      else if (restart)        div_q <= '0;
      else if (div_q >= brp)   div_q <= '0;
      else                     div_q <= div_q + 1'b1;
   end
endmodule

// File: rtl/cbt_edge_det.sv
module cbt_edge_det (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_in,
   output logic rx_s,
   output logic fall
);
   logic rx_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_s <= 1'b1;
         rx_d <= 1'b1;
      end else begin
         rx_s <= rx_in;
         rx_d <= rx_s;
      end
   end

   assign fall = rx_d & ~rx_s;
endmodule

// File: rtl/cbt_sampler.sv
module cbt_sampler
   import cbt_pkg::*;
#(
   parameter bit TRIPLE_OK = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tq_tick,
   input  logic rx_s,
   input  logic triple_en,
   input  logic sample_now,
   output logic rx_bit
);
   logic pick;

   generate
      if (TRIPLE_OK) begin : g_vote
         logic [1:0] hist;
         always_ff @(posedge clk) begin
            if (!rst_n)       hist <= 2'b11;
            else if (tq_tick) hist <= {hist[0], rx_s};
         end
         assign pick = triple_en ? maj3(hist[1], hist[0], rx_s) : rx_s;
      end else begin : g_single
         assign pick = rx_s;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)          rx_bit <= 1'b1;
      else if (sample_now) rx_bit <= pick;
   end
endmodule

// File: rtl/cbt_bit_timer.sv
module cbt_bit_timer
   import cbt_pkg::*;
#(
   parameter int BRP_W     = 6,
   parameter int SEG_W     = 4,
   parameter bit TRIPLE_OK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BRP_W-1:0] brp,
   input  logic [SEG_W-1:0] prop_len,
   input  logic [SEG_W-1:0] ph1_len,
   input  logic [SEG_W-1:0] ph2_len,
   input  logic [SEG_W-1:0] sjw_len,
   input  logic             triple_en,
   input  logic             bus_idle,
   input  logic             tx_dom,
   input  logic             rx_in,
   output logic             rx_bit,
   output logic             sample_stb,
   output logic             bit_start_stb
);
   localparam int LEN_W = SEG_W + 1;

   generate
      if (BRP_W < 1) begin : g_bad_brp
         $error("cbt_bit_timer: BRP_W must be at least 1");
      end
      if (SEG_W < 4) begin : g_bad_seg
         $error("cbt_bit_timer: SEG_W must hold segment lengths up to 8");
      end
   endgenerate

   logic             tq_tick, rx_s, edge_fall, restart, sample_now;
   logic             hard_sync, rs_ok, rs_late, rs_early, early_restart, ts1_done;
   logic             resync_done, hs_armed;
   cbt_seg_e         seg;
   logic [LEN_W-1:0] qcnt, t1_len, t2_len, t1_eff, t2_eff, t1_nom;
   logic [LEN_W-1:0] late_err, late_adj, early_err, sjw_x, ph2_x;

   cbt_quantum_gen #(.BRP_W(BRP_W)) u_qgen (
      .clk(clk), .rst_n(rst_n), .brp(brp), .restart(restart), .tq_tick(tq_tick)
   );

   cbt_edge_det u_edge (
      .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .rx_s(rx_s), .fall(edge_fall)
   );

   cbt_sampler #(.TRIPLE_OK(TRIPLE_OK)) u_smp (
      .clk(clk), .rst_n(rst_n), .tq_tick(tq_tick), .rx_s(rx_s),
      .triple_en(triple_en), .sample_now(sample_now), .rx_bit(rx_bit)
   );

   assign sjw_x     = {1'b0, sjw_len};
   assign ph2_x     = {1'b0, ph2_len};
   assign hard_sync = edge_fall && bus_idle && hs_armed;

   always_comb begin
      t1_nom        = {1'b0, prop_len} + {1'b0, ph1_len};
      late_err      = qcnt + 1'b1;
      late_adj      = (late_err > sjw_x) ? sjw_x : late_err;
      early_err     = ph2_x - qcnt;
      rs_ok         = edge_fall && !tx_dom && !resync_done && !hard_sync;
      rs_late       = rs_ok && (seg == SEG_TS1);
      rs_early      = rs_ok && (seg == SEG_PH2);
      early_restart = rs_early && (early_err <= sjw_x);
      t1_eff        = rs_late  ? (t1_len + late_adj) : t1_len;
      t2_eff        = rs_early ? (ph2_x - sjw_x)     : t2_len;
      restart       = hard_sync || early_restart;
      ts1_done      = tq_tick && (seg == SEG_TS1) && (qcnt >= t1_eff - 1'b1);
      sample_now    = ts1_done && !restart;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seg           <= SEG_SYNC;
         qcnt          <= '0;
         t1_len        <= '0;
         t2_len        <= '0;
         resync_done   <= 1'b0;
         hs_armed      <= 1'b1;
         sample_stb    <= 1'b0;
         bit_start_stb <= 1'b0;
      end else begin
         sample_stb    <= sample_now;
         bit_start_stb <= 1'b0;
         if (hard_sync)     hs_armed <= 1'b0;
         else if (!bus_idle) hs_armed <= 1'b1;
         if (restart) begin
            seg           <= SEG_SYNC;
            qcnt          <= '0;
            bit_start_stb <= 1'b1;
            resync_done   <= hard_sync;
         end else begin
            if (rs_late) begin
               t1_len      <= t1_eff;
               resync_done <= 1'b1;
            end
            if (rs_early) begin
               t2_len      <= t2_eff;
               resync_done <= 1'b1;
            end
            if (tq_tick) begin
               unique case (seg)
                  SEG_SYNC: begin
                     seg    <= SEG_TS1;
                     qcnt   <= '0;
                     t1_len <= t1_nom;
                  end
                  SEG_TS1: begin
                     if (ts1_done) begin
                        seg    <= SEG_PH2;
                        qcnt   <= '0;
                        t2_len <= ph2_x;
                     end else begin
                        qcnt <= qcnt + 1'b1;
                     end
                  end
                  SEG_PH2: begin
                     if (qcnt >= t2_eff - 1'b1) begin
                        seg           <= SEG_SYNC;
                        qcnt          <= '0;
                        bit_start_stb <= 1'b1;
                        resync_done   <= 1'b0;
                     end else begin
                        qcnt <= qcnt + 1'b1;
                     end
                  end
                  default: seg <= SEG_SYNC;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/cbt_bit_timer_chk.sv
module cbt_bit_timer_chk #(
   parameter int BRP_W = 6,
   parameter int SEG_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [BRP_W-1:0] brp,
   input logic [SEG_W-1:0] prop_len,
   input logic [SEG_W-1:0] ph1_len,
   input logic [SEG_W-1:0] ph2_len,
   input logic [SEG_W-1:0] sjw_len,
   input logic             rx_bit,
   input logic             sample_stb,
   input logic             bit_start_stb
);
   logic [15:0] gap;
   logic        seen_smp;
   int          q, lo, hi, bit_max;

   always_comb begin
      q       = int'(brp) + 1;
      lo      = (1 + int'(prop_len) + int'(ph1_len)) * q;
      hi      = lo + int'(sjw_len) * q;
      bit_max = (1 + int'(prop_len) + int'(ph1_len) + int'(ph2_len) + int'(sjw_len)) * q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap      <= '0;
         seen_smp <= 1'b0;
      end else begin
         if (bit_start_stb)     gap <= 16'd1;
         else if (gap != '1)    gap <= gap + 1'b1;
         if (bit_start_stb)     seen_smp <= 1'b0;
         else if (sample_stb)   seen_smp <= 1'b1;
      end
   end

   AST_CFG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (prop_len >= 1 && prop_len <= 8 && ph1_len >= 1 && ph1_len <= 8 &&
       ph2_len >= 2 && ph2_len <= 8 && sjw_len < ph2_len &&
       ({1'b0, prop_len} + {1'b0, ph1_len}) >= {1'b0, ph2_len})); // R1

   AST_BIT_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      bit_start_stb |-> int'(gap) <= bit_max); // R1

   AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
      !(sample_stb && bit_start_stb)); // R2

   AST_SAMPLE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |-> (int'(gap) >= lo && int'(gap) <= hi)); // R4

   AST_ONE_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |-> !seen_smp); // R2

   AST_RXBIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_stb |-> $stable(rx_bit)); // R2
endmodule

bind cbt_bit_timer cbt_bit_timer_chk #(.BRP_W(BRP_W), .SEG_W(SEG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .brp(brp), .prop_len(prop_len), .ph1_len(ph1_len),
   .ph2_len(ph2_len), .sjw_len(sjw_len), .rx_bit(rx_bit),
   .sample_stb(sample_stb), .bit_start_stb(bit_start_stb)
);

// File: tb/cbt_bit_timer_bench.sv
`timescale 1ns/1ps
module cbt_bit_timer_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] brp = 6'd1;
   logic [3:0] prop_len = 4'd2, ph1_len = 4'd3, ph2_len = 4'd3, sjw_len = 4'd2;
   logic       triple_en = 1'b0, bus_idle = 1'b0, tx_dom = 1'b0, rx_in = 1'b1;
   logic       rx_bit, sample_stb, bit_start_stb;
   int         total = 0, bad = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   cbt_bit_timer u_cbt_bit_timer (
      .clk(clk), .rst_n(rst_n), .brp(brp), .prop_len(prop_len), .ph1_len(ph1_len),
      .ph2_len(ph2_len), .sjw_len(sjw_len), .triple_en(triple_en), .bus_idle(bus_idle),
      .tx_dom(tx_dom), .rx_in(rx_in), .rx_bit(rx_bit), .sample_stb(sample_stb),
      .bit_start_stb(bit_start_stb)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic apply_cfg(input int b, input int p, input int a, input int c, input int j,
                            input bit tri_en, input bit idle, input bit txd);
      @(negedge clk);
      rst_n = 1'b0;
      brp = 6'(b); prop_len = 4'(p); ph1_len = 4'(a); ph2_len = 4'(c); sjw_len = 4'(j);
      triple_en = tri_en; bus_idle = idle; tx_dom = txd; rx_in = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic sync_to_start();
      int n = 0;
      do begin @(negedge clk); n++; end while (!bit_start_stb && n < 500);
   endtask

   task automatic skip(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic to_sample(output int d);
      d = 0;
      do begin @(negedge clk); d++; end while (!sample_stb && d < 500);
   endtask

   task automatic to_start(output int d);
      d = 0;
      do begin @(negedge clk); d++; end while (!bit_start_stb && d < 500);
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst_n = 1'b0;
      skip(2);
      check("R9 rx_bit in reset", rx_bit, 1);
      check("R9 sample_stb in reset", sample_stb, 0);
      check("R9 bit_start_stb in reset", bit_start_stb, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 bit_start_stb after release", bit_start_stb, 0);
   endtask

   task automatic t_nominal(input int b, input int p, input int a, input int c, input int j);
      int d;
      int q = b + 1;
      apply_cfg(b, p, a, c, j, 1'b0, 1'b0, 1'b0);
      to_start(d);
      check("R9 first bit length after reset", d, (1 + p + a + c) * q);
      to_sample(d);
      check("R2 sample distance", d, (1 + p + a) * q);
      check("R2 sampled recessive", rx_bit, 1);
      sync_to_start();
      to_start(d);
      check("R1 bit period", d, (1 + p + a + c) * q);
   endtask

   task automatic t_late(input int j, input int k_drive, input int exp);
      int d;
      apply_cfg(1, 2, 3, 3, j, 1'b0, 1'b0, 1'b0);
      sync_to_start();
      skip(k_drive);
      rx_in = 1'b0;
      to_sample(d);
      check("R4 late edge sample distance", k_drive + d, exp);
      check("R2 sampled dominant", rx_bit, 0);
   endtask

   task automatic t_early(input int j, input int exp);
      int d;
      apply_cfg(1, 2, 3, 3, j, 1'b0, 1'b0, 1'b0);
      sync_to_start();
      skip(13);
      rx_in = 1'b0;
      to_start(d);
      check("R5 early edge bit end", 13 + d, exp);
   endtask

   task automatic t_own_tx();
      int d;
      apply_cfg(1, 2, 3, 3, 2, 1'b0, 1'b0, 1'b1);
      sync_to_start();
      skip(3);
      rx_in = 1'b0;
      to_sample(d);
      check("R7 own dominant edge ignored", 3 + d, 12);
   endtask

   task automatic t_once_per_bit();
      int d;
      apply_cfg(1, 2, 3, 3, 1, 1'b0, 1'b0, 1'b0);
      sync_to_start();
      skip(1);
      rx_in = 1'b0;
      skip(3);
      rx_in = 1'b1;
      skip(2);
      rx_in = 1'b0;
      to_sample(d);
      check("R6 second edge in bit ignored", 6 + d, 14);
      rx_in = 1'b1;
      sync_to_start();
      skip(5);
      rx_in = 1'b0;
      skip(2);
      rx_in = 1'b1;
      to_sample(d);
      check("R6 rising edge moves nothing", 7 + d, 14);
   endtask

   task automatic t_hard_sync();
      int d;
      apply_cfg(1, 2, 3, 3, 2, 1'b0, 1'b1, 1'b0);
      sync_to_start();
      skip(5);
      rx_in = 1'b0;
      to_start(d);
      check("R3 hard sync start delay", d, 2);
      to_sample(d);
      check("R3 sample after hard sync", d, 12);
      rx_in = 1'b1;
      sync_to_start();
      skip(3);
      rx_in = 1'b0;
      to_sample(d);
      check("R3 second idle edge not hard sync", 3 + d, 16);
   endtask

   task automatic t_vote(input bit tri_en, input int lo_at, input int lo_len, input int exp,
                         input string req);
      int d;
      apply_cfg(1, 2, 3, 3, 2, tri_en, 1'b0, 1'b1);
      sync_to_start();
      skip(lo_at);
      rx_in = 1'b0;
      skip(lo_len);
      rx_in = 1'b1;
      to_sample(d);
      check(req, rx_bit, exp);
   endtask

   initial begin
      t_reset();
      t_nominal(1, 2, 3, 3, 2);   // R1 R2
      t_nominal(3, 2, 3, 3, 2);   // R1 with slower quantum
      t_nominal(0, 1, 1, 2, 1);   // R1 shortest legal bit
      t_late(2, 3, 16);           // R4 error 2, limit 2
      t_late(2, 7, 16);           // R4 error 4 capped at 2
      t_late(1, 3, 14);           // R4 error 2 capped at 1
      t_early(2, 15);             // R5 error within limit restarts bit
      t_early(1, 16);             // R5 phase 2 cut by limit
      t_own_tx();                 // R7
      t_once_per_bit();           // R6
      t_hard_sync();              // R3
      t_vote(1'b1, 10, 1, 1, "R8 majority rejects glitch");
      t_vote(1'b0, 10, 1, 0, "R8 single sample sees glitch");
      t_vote(1'b1, 8, 3, 0, "R8 majority of two low");
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule